// File: doc/BRIEF.md
# Dual-Port GPIO Pin Block with Change Interrupt

This block holds the pin-side logic of a sixteen-pin general-purpose I/O expander. The pins are split into two byte-wide ports. A register file outside the block owns the output, polarity and direction values and feeds them in continuously. The block turns them into pad output-enable and pad data signals. It captures the synchronized pin levels into a per-port readback byte when the register file strobes a read, and applies per-bit polarity inversion to that byte only.

Each port keeps a raw snapshot of the pin levels it last returned. An active-low interrupt is raised when any pin set as an input no longer matches its port's snapshot. The interrupt goes away when the pin returns to the snapshot level, or when that port is read, which reloads its snapshot. A read of one port leaves the other port's snapshot untouched. A build-time parameter selects push-pull pads or open-drain pads.

Top module: `gpio_chg_irq`

## Requirements
- R1: With push-pull pads (OPEN_DRAIN=0), a direction bit of 1 gives pad_oe bit 0 (high impedance), and a direction bit of 0 gives pad_oe bit 1 with pad_do equal to the output value bit. Both pad signals follow the inputs in the same cycle.
- R2: With open-drain pads (OPEN_DRAIN=1), pad_do is always 0. pad_oe is 1 only for a pin that has direction bit 0 and output bit 0, so an output bit of 1 releases the pin.
- R3: In the clock edge that samples read strobe bit p, rd_data byte p (bits 8p+7..8p) loads the synchronized pin levels XOR the polarity bits. Bits with polarity 1 come back inverted. This happens whatever the direction bits are. Without a strobe, the byte holds its value.
- R4: pin_in passes through a two-flop synchronizer. A level that is set up before clock edge k is what a strobe sampled at edge k+2 captures.
- R5: irq_n is registered. It goes low one edge after an input-configured pin's synchronized level differs from its port's snapshot, which is three edges after the pin changes.
- R6: When every mismatching pin returns to its snapshot level, irq_n goes back high with the same latency and no read is needed.
- R7: A read strobe for port p reloads only port p's snapshot from the synchronized pins. A mismatch pending on the other port keeps irq_n low.
- R8: Pins with direction bit 0 never cause an interrupt. Switching such a pin to input while its level differs from the snapshot makes irq_n go low.
- R9: Change detection compares raw levels, so changing the polarity bits never changes irq_n.
- R10: In reset, irq_n is 1 and rd_data is 0. For the first three edges after reset is released, the snapshots follow the synchronized pins and irq_n stays high, so pins that are already high at start-up do not raise an interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| out_val | input | 16 | Output value bits from the register file |
| pol_val | input | 16 | Polarity inversion bits for readback |
| cfg_val | input | 16 | Direction bits, 1 = input, 0 = output |
| rd_stb | input | 2 | Per-port read strobe; bit p captures byte p |
| pin_in | input | 16 | Asynchronous pin levels from the pads |
| rd_data | output | 16 | Captured readback bytes, port p in byte p |
| irq_n | output | 1 | Active-low change interrupt |
| pad_oe | output | 16 | Pad driver enable |
| pad_do | output | 16 | Pad driver data |

## Verification
The riskiest cases are the clearing cases. The bench raises mismatches on both ports, then reads only one port. A design that clears the whole interrupt on any read would let irq_n go high too early. It also holds a pin on an output while toggling it, flips polarity bits while the pins stay still, and then turns the output back into a mismatching input. A design that compares inverted values, or that does not mask by direction, would give a spurious interrupt or miss the required one. Latency is checked to the exact edge, so a missing or extra synchronizer stage shows up as an early or late capture. Pins that are high while reset is applied must not leave an interrupt pending once reset is released.

// File: rtl/gpio_chg_pkg.sv
// Package: shared helpers for the GPIO change-interrupt block.
// Assumes ports are equal-width slices of one flat pin vector.
package gpio_chg_pkg;

    // Pad driver flavour selected at build time.
    typedef enum logic {
        PAD_PUSH_PULL  = 1'b0,
        PAD_OPEN_DRAIN = 1'b1
    } pad_kind_e;

    // Width of a counter that must reach the value lim.
    function automatic int unsigned cnt_width(input int unsigned lim);
        return (lim < 2) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage synchronizer for asynchronous pin levels.
// Assumes each bit is sampled independently; no bus coherency is implied.
module gpio_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw pin levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= '0;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_next
                // Later stages resolve metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_port_slice.sv
// Module: one port's snapshot, readback capture and change detect.
// Assumes sync_bits is already synchronized; settle reloads the snapshot.
module gpio_port_slice #(
    parameter int unsigned PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          settle,
    input  logic          rd_stb,
    input  logic [PW-1:0] sync_bits,
    input  logic [PW-1:0] pol_bits,
    input  logic [PW-1:0] cfg_bits,
    output logic [PW-1:0] rd_byte,
    output logic          chg
);
    logic [PW-1:0] snap_q;
    logic [PW-1:0] rd_q;

    // Snapshot of raw levels, reloaded on read or while settling.
    always_ff @(posedge clk) begin
        if (!rst_n)                snap_q <= '0;
        else if (settle || rd_stb) snap_q <= sync_bits;
    end

    // Readback byte with polarity applied, formed on the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_q <= '0;
        else if (rd_stb) rd_q <= sync_bits ^ pol_bits;
    end

    // Raw mismatch on input-configured pins only.
    always_comb begin
        chg = |((sync_bits ^ snap_q) & cfg_bits);
    end

    assign rd_byte = rd_q;
endmodule

// File: rtl/gpio_pad_drive.sv
// Module: pad enable/data generation for push-pull or open-drain pads.
// Assumes cfg bit 1 = input; purely combinational.
module gpio_pad_drive #(
    parameter int unsigned                 WIDTH = 16,
    parameter gpio_chg_pkg::pad_kind_e     KIND  = gpio_chg_pkg::PAD_PUSH_PULL
) (
    input  logic [WIDTH-1:0] out_val,
    input  logic [WIDTH-1:0] cfg_val,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_do
);
    generate
        if (KIND == gpio_chg_pkg::PAD_OPEN_DRAIN) begin : g_od
            // Only a low output is driven; a high output is released.
            always_comb begin
                pad_oe = ~cfg_val & ~out_val;
                pad_do = '0;
            end
        end else begin : g_pp
            // Outputs drive their value both ways.
            always_comb begin
                pad_oe = ~cfg_val;
                pad_do = out_val;
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_chg_irq.sv
// Module: top of the GPIO pin block: synchronizer, per-port slices,
// pad drive and the registered active-low change interrupt.
// Assumes the register file holds out/pol/cfg and pulses rd_stb per port.
module gpio_chg_irq
    import gpio_chg_pkg::*;
#(
    parameter int unsigned NUM_PORTS   = 2,
    parameter int unsigned PORT_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          OPEN_DRAIN  = 1'b0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PORTS*PORT_W-1:0] out_val,
    input  logic [NUM_PORTS*PORT_W-1:0] pol_val,
    input  logic [NUM_PORTS*PORT_W-1:0] cfg_val,
    input  logic [NUM_PORTS-1:0]        rd_stb,
    input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
    output logic [NUM_PORTS*PORT_W-1:0] rd_data,
    output logic                        irq_n,
    output logic [NUM_PORTS*PORT_W-1:0] pad_oe,
    output logic [NUM_PORTS*PORT_W-1:0] pad_do
);
    localparam int unsigned W       = NUM_PORTS * PORT_W;
    localparam int unsigned ARM_N   = SYNC_STAGES + 1;
    localparam int unsigned AW      = cnt_width(ARM_N);
    localparam logic [AW-1:0] ARM_LIM = AW'(ARM_N);
    localparam pad_kind_e  KIND     = OPEN_DRAIN ? PAD_OPEN_DRAIN : PAD_PUSH_PULL;

    logic [W-1:0]         pin_sync;
    logic [NUM_PORTS-1:0] port_chg;
    logic [AW-1:0]        arm_q;
    logic                 settling;
    logic                 irq_n_q;

    gpio_sync #(.WIDTH(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_in),
        .q_sync  (pin_sync)
    );

    // Post-reset settle counter; snapshots track pins until it saturates.
    always_ff @(posedge clk) begin
        if (!rst_n)        arm_q <= '0;
        else if (settling) arm_q <= arm_q + 1'b1;
    end

    assign settling = (arm_q != ARM_LIM);

    genvar p;
    generate
        for (p = 0; p < NUM_PORTS; p++) begin : g_port
            gpio_port_slice #(.PW(PORT_W)) u_slice (
                .clk       (clk),
                .rst_n     (rst_n),
                .settle    (settling),
                .rd_stb    (rd_stb[p]),
                .sync_bits (pin_sync[p*PORT_W +: PORT_W]),
                .pol_bits  (pol_val[p*PORT_W +: PORT_W]),
                .cfg_bits  (cfg_val[p*PORT_W +: PORT_W]),
                .rd_byte   (rd_data[p*PORT_W +: PORT_W]),
                .chg       (port_chg[p])
            );
        end
    endgenerate

    // Registered interrupt: low while any port reports a mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_n_q <= 1'b1;
        else if (settling) irq_n_q <= 1'b1;
        else               irq_n_q <= ~(|port_chg);
    end

    assign irq_n = irq_n_q;

    gpio_pad_drive #(.WIDTH(W), .KIND(KIND)) u_pad (
        .out_val (out_val),
        .cfg_val (cfg_val),
        .pad_oe  (pad_oe),
        .pad_do  (pad_do)
    );
endmodule

// File: rtl/gpio_chg_irq_chk.sv
// Module: assertion checker bound to gpio_chg_irq.
// Assumes it observes the top-level ports only.
module gpio_chg_irq_chk #(
    parameter int unsigned W  = 16,
    parameter int unsigned NP = 2,
    parameter bit          OD = 1'b0
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  out_val,
    input logic [W-1:0]  cfg_val,
    input logic [NP-1:0] rd_stb,
    input logic [W-1:0]  rd_data,
    input logic          irq_n,
    input logic [W-1:0]  pad_oe,
    input logic [W-1:0]  pad_do
);
    // An input-configured pin is never driven (R1, R2).
    p_input_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & cfg_val) == '0);

    // Open drain never drives a one (R2).
    p_od_no_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        OD |-> ((pad_do == '0) && ((pad_oe & out_val) == '0)));

    // Readback holds without a strobe (R3).
    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb == '0) |=> $stable(rd_data));

    // An interrupt needs at least one input pin in the prior cycle (R8).
    p_irq_needs_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> $past(|cfg_val));

    // First cycle after reset release the interrupt is idle (R10).
    p_settle_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> irq_n);
endmodule

bind gpio_chg_irq gpio_chg_irq_chk #(
    .W  (NUM_PORTS*PORT_W),
    .NP (NUM_PORTS),
    .OD (OPEN_DRAIN)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .out_val (out_val),
    .cfg_val (cfg_val),
    .rd_stb  (rd_stb),
    .rd_data (rd_data),
    .irq_n   (irq_n),
    .pad_oe  (pad_oe),
    .pad_do  (pad_do)
);

// File: tb/gpio_chg_irq_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every cycle, plus directed checks.
module gpio_chg_irq_tb_top;
    localparam real CLK_HALF = 2.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] out_val = 16'h0000;
    logic [15:0] pol_val = 16'h0000;
    logic [15:0] cfg_val = 16'hFFFF;
    logic [1:0]  rd_stb = 2'b00;
    logic [15:0] pin_in = 16'hA53C;
    logic [15:0] rd_data, pad_oe, pad_do;
    logic        irq_n;
    logic [15:0] od_rd_data, od_pad_oe, od_pad_do;
    logic        od_irq_n;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #(CLK_HALF) clk = ~clk;

    gpio_chg_irq dut_i (
        .clk(clk), .rst_n(rst_n), .out_val(out_val), .pol_val(pol_val),
        .cfg_val(cfg_val), .rd_stb(rd_stb), .pin_in(pin_in),
        .rd_data(rd_data), .irq_n(irq_n), .pad_oe(pad_oe), .pad_do(pad_do)
    );

    gpio_chg_irq #(.OPEN_DRAIN(1'b1)) dut_od_i (
        .clk(clk), .rst_n(rst_n), .out_val(out_val), .pol_val(pol_val),
        .cfg_val(cfg_val), .rd_stb(rd_stb), .pin_in(pin_in),
        .rd_data(od_rd_data), .irq_n(od_irq_n), .pad_oe(od_pad_oe), .pad_do(od_pad_do)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model state.
    logic [15:0] pin_hist[$];
    logic [15:0] m_snap, m_rd;
    logic        m_irq;
    int          m_age;

    // Model update at each rising edge, from inputs held since the falling edge.
    always @(posedge clk) begin
        logic [15:0] seen;
        logic [15:0] diff;
        bit          calm;
        if (!rst_n) begin
            pin_hist = {16'h0000, 16'h0000};
            m_snap = 16'h0000; m_rd = 16'h0000; m_irq = 1'b1; m_age = 0;
        end else begin
            seen = pin_hist[0];
            calm = (m_age >= 3);
            diff = (seen ^ m_snap) & cfg_val;
            m_irq = calm ? (diff == 16'h0000) : 1'b1;
            for (int p = 0; p < 2; p++) begin
                if (!calm || rd_stb[p]) m_snap[p*8 +: 8] = seen[p*8 +: 8];
                if (rd_stb[p]) m_rd[p*8 +: 8] = seen[p*8 +: 8] ^ pol_val[p*8 +: 8];
            end
            if (m_age < 3) m_age++;
            void'(pin_hist.pop_front());
            pin_hist.push_back(pin_in);
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (!done && pin_hist.size() == 2) begin
            check("R3/R4 model rd_data", rd_data, m_rd);
            check("R5/R6 model irq_n", {15'd0, irq_n}, {15'd0, m_irq});
            check("R1 model pad_oe", pad_oe, ~cfg_val);
            check("R1 model pad_do", pad_do, out_val);
        end
    end

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_ports(input logic [1:0] which);
        rd_stb = which;
        edges(1);
        rd_stb = 2'b00;
    endtask

    initial begin
        #(CLK_HALF * 2.0 * 200000.0);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        edges(4);
        check("R10 reset irq_n", {15'd0, irq_n}, 16'h0001);
        check("R10 reset rd_data", rd_data, 16'h0000);
        rst_n = 1'b1;
        edges(6);
        check("R10 no irq for pins high at start", {15'd0, irq_n}, 16'h0001);

        read_ports(2'b11);
        check("R3 plain readback", rd_data, 16'hA53C);
        pol_val = 16'h00FF;
        read_ports(2'b01);
        check("R3 inverted low byte", rd_data, 16'hA5C3);

        // Latency of a change on port 0 bit 1.
        pin_in = 16'hA53E;
        edges(2);
        check("R4 irq not yet after two edges", {15'd0, irq_n}, 16'h0001);
        edges(1);
        check("R5 irq after three edges", {15'd0, irq_n}, 16'h0000);
        pin_in = 16'hA53C;
        edges(3);
        check("R6 irq released on return", {15'd0, irq_n}, 16'h0001);

        // Mismatch on both ports, read one at a time.
        pin_in = 16'hA73D;
        edges(3);
        check("R5 irq both ports", {15'd0, irq_n}, 16'h0000);
        read_ports(2'b10);
        edges(2);
        check("R7 port1 read keeps port0 irq", {15'd0, irq_n}, 16'h0000);
        read_ports(2'b01);
        edges(1);
        check("R7 port0 read clears", {15'd0, irq_n}, 16'h0001);

        // Output pin toggles, polarity flips.
        cfg_val = 16'hFFEF;
        pin_in  = 16'hA72D;
        edges(4);
        check("R8 output pin ignored", {15'd0, irq_n}, 16'h0001);
        pol_val = 16'hFFFF;
        edges(4);
        check("R9 polarity change ignored", {15'd0, irq_n}, 16'h0001);
        cfg_val = 16'hFFFF;
        edges(1);
        check("R8 switch to input raises irq", {15'd0, irq_n}, 16'h0000);
        read_ports(2'b01);
        edges(1);
        check("R8 cleared by read", {15'd0, irq_n}, 16'h0001);

        // Pad drive, both variants.
        cfg_val = 16'h0F0F;
        out_val = 16'h3355;
        edges(1);
        check("R1 push-pull oe", pad_oe, 16'hF0F0);
        check("R1 push-pull data", pad_do, 16'h3355);
        check("R2 open-drain oe", od_pad_oe, 16'hC0A0);
        check("R2 open-drain data", od_pad_do, 16'h0000);

        // Readback of output-configured pins.
        cfg_val = 16'h0000;
        pol_val = 16'h0000;
        pin_in  = 16'h5A69;
        edges(2);
        read_ports(2'b11);
        check("R3 output pins read back", rd_data, 16'h5A69);

        // Random traffic checked by the model.
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 4) == 0) pin_in = pin_in ^ (16'h1 << ($urandom % 16));
            if (($urandom % 16) == 0) cfg_val = 16'($urandom);
            if (($urandom % 16) == 0) pol_val = 16'($urandom);
            out_val = 16'($urandom);
            rd_stb  = 2'($urandom % 4 == 0 ? $urandom : 0);
            edges(1);
        end
        rd_stb = 2'b00;
        edges(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule